// File: doc/BRIEF.md
# Divide/Square-Root Early-Retire Qualifier

This block sits beside a floating-point divide and square-root unit. It looks at each instruction in the cycle the instruction issues. From the opcode class, the operand signs, exponents and special-value flags, the trap qualifier, the inexact-enable status bit and the predicted result exponent, it decides whether the instruction can never raise an exception. An instruction that qualifies may retire before its quotient or root exists.

The decision is registered and held on `early_o`. A down-counter loaded at issue produces a one-cycle `retire_rdy_o` strobe. An early instruction gets the strobe after a base latency of 11 cycles. Any other instruction gets it after the base latency plus the unit latency of its type. Only one instruction is tracked at a time. `busy_o` tells the issuer to stall, and an issue strobe seen while busy is dropped.

Top module: `fper_early_retire`

## Requirements
- R1: After synchronous active-low reset, `busy_o`, `early_o` and `retire_rdy_o` are all 0.
- R2: Opcode classes are encoded as 0 other, 1 single divide, 2 double divide, 3 single square root, 4 double square root; codes 5 to 7 act as other. An instruction of class other never qualifies, and its strobe comes 11 cycles after issue.
- R3: A square root whose operand A sign bit is 1 does not qualify. A square root with a positive operand and no other refusal does qualify.
- R4: A divide whose operand A exponent is zero, or whose operand B exponent is zero, does not qualify.
- R5: An instruction with the NaN/infinity flag set on either operand does not qualify.
- R6: An instruction does not qualify when `trap_inexact_i` is 1 or when `inexact_en_i` is 0.
- R7: A double divide qualifies only when its result exponent is strictly between the lower bound (default 0x002) and the upper bound (default 0x3FF). A value equal to either bound is refused.
- R8: A single divide qualifies only when its result exponent is strictly below the upper bound (default 0x07F) and strictly above the lower bound (default 0x382). With these default bounds no single divide qualifies.
- R9: For a qualifying instruction, `retire_rdy_o` is high for exactly one cycle, 11 clock edges after the edge that accepted the issue.
- R10: For a non-qualifying divide or square root, the strobe comes 11 plus the unit latency edges after issue. The default unit latencies are 9 (single divide), 12 (double divide), 15 (single square root) and 15 (double square root).
- R11: `busy_o` is 1 from the edge after an accepted issue until the strobe cycle. An issue strobe while busy is ignored: it produces no strobe and does not change `early_o`.
- R12: `early_o` holds the decision of the most recently accepted issue until the next accepted issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | Issue strobe |
| op_i | input | 3 | Opcode class |
| a_sign_i | input | 1 | Sign of operand A |
| a_exp_i | input | EXP_W | Exponent of operand A |
| a_nan_inf_i | input | 1 | Operand A is NaN or infinity |
| b_exp_i | input | EXP_W | Exponent of operand B |
| b_nan_inf_i | input | 1 | Operand B is NaN or infinity |
| trap_inexact_i | input | 1 | Trap qualifier includes inexact |
| inexact_en_i | input | 1 | Inexact-enable status bit |
| res_exp_i | input | EXP_W | Predicted result exponent |
| busy_o | output | 1 | Countdown in flight; issuer must stall |
| early_o | output | 1 | Registered early-retire decision |
| retire_rdy_o | output | 1 | One-cycle retire-ready strobe |

## Verification
A wrong eligibility term shows up in `early_o` on the first edge after issue. The same error shows up as a strobe off by the whole unit latency, between 9 and 15 cycles. A counter that loads or decrements wrongly shows up only when the strobe is due, as a strobe that is early, late, missing, repeated or out of step with the scoreboard. A fault in the busy gate appears as an extra strobe, or as a change in `early_o` after an issue that should have been dropped.

// File: rtl/fper_pkg.sv
// Package: opcode classes and small helpers shared by the early-retire block.
// Assumes the opcode class arrives as a 3-bit code; unused codes mean "other".
package fper_pkg;

    typedef enum logic [2:0] {
        OPC_OTHER  = 3'd0,
        OPC_DIV_S  = 3'd1,
        OPC_DIV_D  = 3'd2,
        OPC_SQRT_S = 3'd3,
        OPC_SQRT_D = 3'd4
    } opc_e;

    // Largest of four latencies, used to size the countdown.
    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/fper_qualify.sv
// Module: fper_qualify
// Combinational eligibility check made in the issue cycle. Exponents are
// compared as unsigned values against per-precision bounds; the bounds apply
// to divides only, and the zero-exponent tests apply to divides only.
module fper_qualify
    import fper_pkg::*;
#(
    parameter int unsigned          EXP_W  = 11,
    parameter logic [EXP_W-1:0]     DBL_HI = 'h3FF,
    parameter logic [EXP_W-1:0]     DBL_LO = 'h002,
    parameter logic [EXP_W-1:0]     SGL_HI = 'h07F,
    parameter logic [EXP_W-1:0]     SGL_LO = 'h382
) (
    input  logic [2:0]       op,
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic             a_special,
    input  logic [EXP_W-1:0] b_exp,
    input  logic             b_special,
    input  logic             trap_inexact,
    input  logic             inexact_en,
    input  logic [EXP_W-1:0] res_exp,
    output logic             eligible
);

    logic is_div_s, is_div_d, is_sqrt;
    logic state_ok, operands_ok, range_ok;

    // Decode the opcode class.
    always_comb begin
        is_div_s = (op == OPC_DIV_S);
        is_div_d = (op == OPC_DIV_D);
        is_sqrt  = (op == OPC_SQRT_S) || (op == OPC_SQRT_D);
    end

    // Check the architectural state and the special-value flags.
    always_comb begin
        state_ok = !trap_inexact && inexact_en && !a_special && !b_special;
    end

    // Check the operand and result-exponent limits for each class.
    always_comb begin
        range_ok = 1'b0;
        if (is_div_d)
            range_ok = (res_exp > DBL_LO) && (res_exp < DBL_HI);
        else if (is_div_s)
            range_ok = (res_exp > SGL_LO) && (res_exp < SGL_HI);
        if (is_sqrt)
            operands_ok = !a_sign;
        else if (is_div_s || is_div_d)
            operands_ok = (a_exp != '0) && (b_exp != '0) && range_ok;
        else
            operands_ok = 1'b0;
    end

    // Combine the class, state and operand checks.
    always_comb begin
        eligible = state_ok && operands_ok;
    end

endmodule

// File: rtl/fper_lat_sel.sv
// Module: fper_lat_sel
// Picks the total retire latency: the base latency alone for an early
// instruction, base plus the unit latency of its class otherwise.
// Assumes CNT_W can hold BASE_LAT plus the largest unit latency.
module fper_lat_sel
    import fper_pkg::*;
#(
    parameter int unsigned BASE_LAT  = 11,
    parameter int unsigned LAT_DIVS  = 9,
    parameter int unsigned LAT_DIVT  = 12,
    parameter int unsigned LAT_SQRTS = 15,
    parameter int unsigned LAT_SQRTT = 15,
    parameter int unsigned CNT_W     = 5
) (
    input  logic [2:0]       op,
    input  logic             eligible,
    output logic [CNT_W-1:0] total
);

    logic [CNT_W-1:0] unit;

    // Look up the unit latency of the class.
    always_comb begin
        case (op)
            OPC_DIV_S:  unit = CNT_W'(LAT_DIVS);
            OPC_DIV_D:  unit = CNT_W'(LAT_DIVT);
            OPC_SQRT_S: unit = CNT_W'(LAT_SQRTS);
            OPC_SQRT_D: unit = CNT_W'(LAT_SQRTT);
            default:    unit = '0;
        endcase
    end

    // Add the unit latency unless the instruction retires early.
    always_comb begin
        total = CNT_W'(BASE_LAT) + (eligible ? '0 : unit);
    end

endmodule

// File: rtl/fper_countdown.sv
// Module: fper_countdown
// Tracks one issued instruction. On load it latches the decision and counts
// down total-1 edges, then raises the strobe for one cycle and goes idle.
// Assumes total is at least 1 and that load is never asserted while active.
module fper_countdown #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] total,
    input  logic             early_in,
    output logic             active,
    output logic             early,
    output logic             strobe
);

    logic [CNT_W-1:0] cnt;

    // Load on issue, count down, and raise the strobe when the count ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            early  <= 1'b0;
            strobe <= 1'b0;
        end else begin
            strobe <= active && (cnt == '0);
            if (load) begin
                active <= 1'b1;
                cnt    <= total - CNT_W'(1);
                early  <= early_in;
            end else if (active) begin
                if (cnt == '0) active <= 1'b0;
                else           cnt    <= cnt - CNT_W'(1);
            end
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe); // R9
    AST_IDLE_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !active); // R11
    AST_BUSY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> active); // R11
    AST_EARLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(early)); // R12

endmodule

// File: rtl/fper_early_retire.sv
// Module: fper_early_retire (top)
// Decides at issue whether a divide or square root may retire early, and
// produces the retire-ready strobe after the matching latency. One
// instruction in flight at a time; an issue strobe while busy is dropped.
module fper_early_retire
    import fper_pkg::*;
#(
    parameter int unsigned      EXP_W     = 11,
    parameter int unsigned      BASE_LAT  = 11,
    parameter int unsigned      LAT_DIVS  = 9,
    parameter int unsigned      LAT_DIVT  = 12,
    parameter int unsigned      LAT_SQRTS = 15,
    parameter int unsigned      LAT_SQRTT = 15,
    parameter logic [EXP_W-1:0] DBL_HI    = 'h3FF,
    parameter logic [EXP_W-1:0] DBL_LO    = 'h002,
    parameter logic [EXP_W-1:0] SGL_HI    = 'h07F,
    parameter logic [EXP_W-1:0] SGL_LO    = 'h382
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic [2:0]       op_i,
    input  logic             a_sign_i,
    input  logic [EXP_W-1:0] a_exp_i,
    input  logic             a_nan_inf_i,
    input  logic [EXP_W-1:0] b_exp_i,
    input  logic             b_nan_inf_i,
    input  logic             trap_inexact_i,
    input  logic             inexact_en_i,
    input  logic [EXP_W-1:0] res_exp_i,
    output logic             busy_o,
    output logic             early_o,
    output logic             retire_rdy_o
);

    localparam int unsigned MAX_UNIT = max4(LAT_DIVS, LAT_DIVT, LAT_SQRTS, LAT_SQRTT);
    localparam int unsigned MAX_TOT  = BASE_LAT + MAX_UNIT;
    localparam int unsigned CNT_W    = $clog2(MAX_TOT + 1);

    logic             eligible;
    logic [CNT_W-1:0] total;
    logic             active;
    logic             accept;

    fper_qualify #(
        .EXP_W(EXP_W), .DBL_HI(DBL_HI), .DBL_LO(DBL_LO),
        .SGL_HI(SGL_HI), .SGL_LO(SGL_LO)
    ) u_qual (
        .op(op_i), .a_sign(a_sign_i), .a_exp(a_exp_i), .a_special(a_nan_inf_i),
        .b_exp(b_exp_i), .b_special(b_nan_inf_i), .trap_inexact(trap_inexact_i),
        .inexact_en(inexact_en_i), .res_exp(res_exp_i), .eligible(eligible)
    );

    fper_lat_sel #(
        .BASE_LAT(BASE_LAT), .LAT_DIVS(LAT_DIVS), .LAT_DIVT(LAT_DIVT),
        .LAT_SQRTS(LAT_SQRTS), .LAT_SQRTT(LAT_SQRTT), .CNT_W(CNT_W)
    ) u_lat (
        .op(op_i), .eligible(eligible), .total(total)
    );

    // Accept an issue only when nothing is in flight.
    always_comb begin
        accept = issue_i && !active;
    end

    fper_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(accept), .total(total),
        .early_in(eligible), .active(active), .early(early_o),
        .strobe(retire_rdy_o)
    );

    // Export the stall indication.
    always_comb begin
        busy_o = active;
    end

    AST_OTHER_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OPC_OTHER) |-> !eligible); // R2
    AST_SQRT_NEGATIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (((op_i == OPC_SQRT_S) || (op_i == OPC_SQRT_D)) && a_sign_i) |-> !eligible); // R3
    AST_SPECIAL_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (a_nan_inf_i || b_nan_inf_i) |-> !eligible); // R5
    AST_INEXACT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_inexact_i || !inexact_en_i) |-> !eligible); // R6
    AST_DROP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && busy_o) |=> $stable(early_o)); // R11

endmodule

// File: tb/sim_fper_early_retire.sv
`timescale 1ns/1ps
module sim_fper_early_retire;

    typedef struct {
        logic  early;
        int    lat;
        int    cyc;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic        a_sign_i = 1'b0;
    logic [10:0] a_exp_i = '0;
    logic        a_nan_inf_i = 1'b0;
    logic [10:0] b_exp_i = '0;
    logic        b_nan_inf_i = 1'b0;
    logic        trap_inexact_i = 1'b0;
    logic        inexact_en_i = 1'b1;
    logic [10:0] res_exp_i = '0;
    logic        busy_o, early_o, retire_rdy_o;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fper_early_retire u0 (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
        .a_sign_i(a_sign_i), .a_exp_i(a_exp_i), .a_nan_inf_i(a_nan_inf_i),
        .b_exp_i(b_exp_i), .b_nan_inf_i(b_nan_inf_i),
        .trap_inexact_i(trap_inexact_i), .inexact_en_i(inexact_en_i),
        .res_exp_i(res_exp_i), .busy_o(busy_o), .early_o(early_o),
        .retire_rdy_o(retire_rdy_o)
    );

    task automatic chk(input logic ok, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    // Monitor: pop the scoreboard on each strobe, compare decision and latency.
    always @(negedge clk) begin
        if (rst_n && retire_rdy_o) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R11 unexpected strobe", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(early_o == e.early, {e.tag, " early_o"}, int'(early_o), int'(e.early));
                chk((cyc - e.cyc) == e.lat, {e.tag, " latency"}, cyc - e.cyc, e.lat);
            end
        end
    end

    // Driver: wait until idle, issue one instruction, push the expected item.
    task automatic issue(input logic [2:0] op, input logic asg, input logic [10:0] aexp,
                         input logic ana, input logic [10:0] bexp, input logic bna,
                         input logic trp, input logic ien, input logic [10:0] rexp,
                         input logic exp_early, input int exp_lat, input string tag);
        exp_t e;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        op_i = op; a_sign_i = asg; a_exp_i = aexp; a_nan_inf_i = ana;
        b_exp_i = bexp; b_nan_inf_i = bna; trap_inexact_i = trp;
        inexact_en_i = ien; res_exp_i = rexp; issue_i = 1'b1;
        e.early = exp_early; e.lat = exp_lat; e.cyc = cyc + 1; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        issue_i = 1'b0;
        chk(busy_o == 1'b1, {tag, " R11 busy after issue"}, int'(busy_o), 1);
        chk(early_o == exp_early, {tag, " R12 early_o after issue"}, int'(early_o), int'(exp_early));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #100000;
        chk(1'b0, "watchdog expired", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy_o == 1'b0, "R1 busy_o in reset", int'(busy_o), 0);
        chk(early_o == 1'b0, "R1 early_o in reset", int'(early_o), 0);
        chk(retire_rdy_o == 1'b0, "R1 retire_rdy_o in reset", int'(retire_rdy_o), 0);
        rst_n = 1'b1;

        // R7 / R9 double divide, in range
        issue(3'd2, 0, 11'h400, 0, 11'h400, 0, 0, 1, 11'h100, 1, 11, "R7 R9 divD mid");
        issue(3'd2, 0, 11'h400, 0, 11'h400, 0, 0, 1, 11'h003, 1, 11, "R7 divD lo+1");
        issue(3'd2, 0, 11'h400, 0, 11'h400, 0, 0, 1, 11'h3FE, 1, 11, "R7 divD hi-1");
        // R7 / R10 double divide at the bounds
        issue(3'd2, 0, 11'h400, 0, 11'h400, 0, 0, 1, 11'h3FF, 0, 23, "R7 R10 divD hi");
        issue(3'd2, 0, 11'h400, 0, 11'h400, 0, 0, 1, 11'h002, 0, 23, "R7 divD lo");
        // R8 / R10 single divide never qualifies with default bounds
        issue(3'd1, 0, 11'h080, 0, 11'h080, 0, 0, 1, 11'h200, 0, 20, "R8 R10 divS mid");
        issue(3'd1, 0, 11'h080, 0, 11'h080, 0, 0, 1, 11'h07E, 0, 20, "R8 divS low");
        // R3 square roots
        issue(3'd3, 0, 11'h080, 0, 11'h000, 0, 0, 1, 11'h000, 1, 11, "R3 sqrtS pos");
        issue(3'd3, 1, 11'h080, 0, 11'h000, 0, 0, 1, 11'h000, 0, 26, "R3 R10 sqrtS neg");
        issue(3'd4, 1, 11'h400, 0, 11'h000, 0, 0, 1, 11'h000, 0, 26, "R3 R10 sqrtD neg");
        issue(3'd4, 0, 11'h400, 0, 11'h000, 0, 0, 1, 11'h000, 1, 11, "R3 sqrtD pos");
        // R4 zero exponents
        issue(3'd2, 0, 11'h000, 0, 11'h400, 0, 0, 1, 11'h100, 0, 23, "R4 divD a_exp 0");
        issue(3'd2, 0, 11'h400, 0, 11'h000, 0, 0, 1, 11'h100, 0, 23, "R4 divD b_exp 0");
        // R5 special operands
        issue(3'd2, 0, 11'h400, 1, 11'h400, 0, 0, 1, 11'h100, 0, 23, "R5 divD a special");
        issue(3'd2, 0, 11'h400, 0, 11'h400, 1, 0, 1, 11'h100, 0, 23, "R5 divD b special");
        issue(3'd4, 0, 11'h400, 1, 11'h000, 0, 0, 1, 11'h000, 0, 26, "R5 sqrtD special");
        // R6 trap qualifier and status bit
        issue(3'd2, 0, 11'h400, 0, 11'h400, 0, 1, 1, 11'h100, 0, 23, "R6 divD inexact trap");
        issue(3'd2, 0, 11'h400, 0, 11'h400, 0, 0, 0, 11'h100, 0, 23, "R6 divD status 0");
        // R2 other classes
        issue(3'd0, 0, 11'h400, 0, 11'h400, 0, 0, 1, 11'h100, 0, 11, "R2 other 0");
        issue(3'd6, 0, 11'h400, 0, 11'h400, 0, 0, 1, 11'h100, 0, 11, "R2 other 6");

        // R11 / R12: issue a qualifying divide, then poke while busy with a refused one
        issue(3'd2, 0, 11'h400, 0, 11'h400, 0, 0, 1, 11'h100, 1, 11, "R11 base");
        repeat (2) @(negedge clk);
        op_i = 3'd0; issue_i = 1'b1;
        @(negedge clk);
        issue_i = 1'b0;
        @(negedge clk);
        chk(early_o == 1'b1, "R11 R12 early_o after dropped issue", int'(early_o), 1);
        chk(busy_o == 1'b1, "R11 still busy after dropped issue", int'(busy_o), 1);

        // Drain and make sure nothing further arrives.
        while (sb.size() != 0) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(busy_o == 1'b0, "R11 idle at end", int'(busy_o), 0);
        chk(early_o == 1'b1, "R12 early_o held when idle", int'(early_o), 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule